// File: doc/BRIEF.md
# Chunked DMA Address Sequencer

This block runs one error-correction transfer that is cut into fixed-size chunks. Software loads a base address for the main data area, a base address for the spare area, a chunk count and a direction, enables the engine and writes the start bit. The sequencer then walks through the chunks and, for each one, asks a memory mover for the main-area slice and then for the spare-area slice, each with its own address and length. When the last chunk has been acknowledged it raises a one-cycle completion event.

The main area advances by a fixed 1 KiB data step per chunk. The spare area advances by the spare step plus a few bytes of room for a per-chunk status word. A count of one lets software trigger each step by hand; a count equal to the number of steps in a page covers the whole page with a single start. A host-configuration register carries the burst type and the ECC layout choice straight to the mover.

Top module: `chunk_dma_seq`

## Requirements
- R1: After reset no request is valid, done_o is low, and every register reads back as zero.
- R2: A transfer starts only on a write to the control register (index 2) with bit 31 set while the engine-enable bit (bit 0 of index 0) is 1; a start with the engine off, or a control write with bit 31 clear, issues no request and leaves the busy bit at 0.
- R3: The main request of chunk n carries address main_base + n*DATA_STEP (DATA_STEP = 1024) and length DATA_STEP.
- R4: The spare request of chunk n carries address spare_base + n*(SPARE_STEP + STAT_BYTES) and length SPARE_STEP + STAT_BYTES (32 + 4 by default).
- R5: Within a chunk the main request (req_spare_o = 0) is acknowledged before the spare request (req_spare_o = 1) appears, the spare request follows a main acknowledge in the next cycle, and a request holds its address and area stable until acknowledged.
- R6: Exactly chunk-count chunks are issued; done_o is high for one cycle, the cycle after the final spare acknowledge, and no request follows.
- R7: A chunk count of zero raises done_o in the cycle after the start write with no request at all.
- R8: While a transfer runs, control bit 31 reads 1 and a further start write is ignored: addresses, direction and chunk count of the running transfer are unchanged.
- R9: Control bit 1 at start selects reading from flash (req_rd_o = 1) for every request of that transfer; it reads back at control bit 1.
- R10: Host-configuration register (index 1) bit 0 drives burst_incr_o (1 = incrementing burst) and bit 2 drives interleave_o (1 = interleaved layout, 0 = packed); other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 enable, 1 host config, 2 control, 3 main base, 4 spare base, 5 chunk count |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register at reg_addr_i |
| req_valid_o | output | 1 | Area request valid |
| req_spare_o | output | 1 | 0 = main-area request, 1 = spare-area request |
| req_addr_o | output | ADDR_W | Request start address |
| req_len_o | output | LEN_W | Request length in bytes |
| req_rd_o | output | 1 | 1 = flash to memory, 0 = memory to flash |
| req_ack_i | input | 1 | Mover acknowledge; completes the request in the same cycle |
| burst_incr_o | output | 1 | Incrementing burst selected |
| interleave_o | output | 1 | Interleaved ECC layout selected |
| done_o | output | 1 | One-cycle transfer-complete event |

## Verification
The hardest case to reach is a second start landing while a request is held open, because it needs a register write timed against an acknowledge that has not yet arrived. The bench holds the acknowledge of the first main request back, reads the busy bit and writes a start with opposite direction during that hold, then checks every later address and direction against the original transfer. Random bases, counts, directions and acknowledge delays from a fixed seed cover the address walk, with directed zero-count, whole-page and engine-off starts.

// File: rtl/chunk_dma_seq_pkg.sv
package chunk_dma_seq_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] IDX_ENG   = 3'd0;
  localparam logic [2:0] IDX_HOST  = 3'd1;
  localparam logic [2:0] IDX_CTRL  = 3'd2;
  localparam logic [2:0] IDX_MAIN  = 3'd3;
  localparam logic [2:0] IDX_SPARE = 3'd4;
  localparam logic [2:0] IDX_COUNT = 3'd5;

  localparam int BIT_START = 31;
  localparam int BIT_RD    = 1;
  localparam int BIT_INCR  = 0;
  localparam int BIT_ILV   = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAIN,
    ST_SPARE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/chunk_dma_seq_regs.sv
module chunk_dma_seq_regs
  import chunk_dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              accept_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              eng_en_o,
  output logic              incr_o,
  output logic              ilv_o,
  output logic              start_req_o,
  output logic              start_rd_o,
  output logic              dir_rd_o,
  output logic [ADDR_W-1:0] main_base_o,
  output logic [ADDR_W-1:0] spare_base_o,
  output logic [CNT_W-1:0]  count_o
);
  logic ctrl_wr;
  assign ctrl_wr     = we_i && (addr_i == IDX_CTRL);
  assign start_req_o = ctrl_wr && wdata_i[BIT_START];
  assign start_rd_o  = wdata_i[BIT_RD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_en_o     <= 1'b0;
      incr_o       <= 1'b0;
      ilv_o        <= 1'b0;
      dir_rd_o     <= 1'b0;
      main_base_o  <= '0;
      spare_base_o <= '0;
      count_o      <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          IDX_ENG:   eng_en_o <= wdata_i[0];
          IDX_HOST: begin
            incr_o <= wdata_i[BIT_INCR];
            ilv_o  <= wdata_i[BIT_ILV];
          end
          IDX_MAIN:  main_base_o  <= wdata_i[ADDR_W-1:0];
          IDX_SPARE: spare_base_o <= wdata_i[ADDR_W-1:0];
          IDX_COUNT: count_o      <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
      // direction only moves with an accepted start
      if (accept_i) dir_rd_o <= start_rd_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_ENG:   rdata_o[0] = eng_en_o;
      IDX_HOST: begin
        rdata_o[BIT_INCR] = incr_o;
        rdata_o[BIT_ILV]  = ilv_o;
      end
      IDX_CTRL: begin
        rdata_o[BIT_START] = busy_i;
        rdata_o[BIT_RD]    = dir_rd_o;
      end
      IDX_MAIN:  rdata_o = REG_W'(main_base_o);
      IDX_SPARE: rdata_o = REG_W'(spare_base_o);
      IDX_COUNT: rdata_o = REG_W'(count_o);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/chunk_dma_seq_fsm.sv
module chunk_dma_seq_fsm
  import chunk_dma_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ack_i,
  output logic             valid_o,
  output logic             spare_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             adv_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q;

  always_comb begin
    state_d = state_q;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = (count_i == '0) ? ST_DONE : ST_MAIN;
      ST_MAIN:  if (ack_i) state_d = ST_SPARE;
      ST_SPARE: if (ack_i) begin
        if (left_q == CNT_W'(1)) state_d = ST_DONE;
        else begin
          state_d = ST_MAIN;
          adv_o   = 1'b1;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) left_q <= count_i;
      else if (adv_o) left_q <= left_q - CNT_W'(1);
    end
  end

  assign valid_o = (state_q == ST_MAIN) || (state_q == ST_SPARE);
  assign spare_o = (state_q == ST_SPARE);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/chunk_dma_seq_addr.sv
module chunk_dma_seq_addr #(
  parameter int ADDR_W     = 32,
  parameter int DATA_STEP  = 1024,
  parameter int SPARE_STEP = 32,
  parameter int STAT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] main_base_i,
  input  logic [ADDR_W-1:0] spare_base_i,
  output logic [ADDR_W-1:0] main_addr_o,
  output logic [ADDR_W-1:0] spare_addr_o
);
  localparam logic [ADDR_W-1:0] MAIN_INC  = ADDR_W'(DATA_STEP);
  localparam logic [ADDR_W-1:0] SPARE_INC = ADDR_W'(SPARE_STEP + STAT_BYTES);

  // running pointers: one adder each, no multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_addr_o  <= '0;
      spare_addr_o <= '0;
    end else if (load_i) begin
      main_addr_o  <= main_base_i;
      spare_addr_o <= spare_base_i;
    end else if (adv_i) begin
      main_addr_o  <= main_addr_o + MAIN_INC;
      spare_addr_o <= spare_addr_o + SPARE_INC;
    end
  end
endmodule

// File: rtl/chunk_dma_seq.sv
module chunk_dma_seq
  import chunk_dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 8,
  parameter int DATA_STEP  = 1024,
  parameter int SPARE_STEP = 32,
  parameter int STAT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              req_valid_o,
  output logic              req_spare_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_rd_o,
  input  logic              req_ack_i,
  output logic              burst_incr_o,
  output logic              interleave_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0] MAIN_LEN  = LEN_W'(DATA_STEP);
  localparam logic [LEN_W-1:0] SPARE_LEN = LEN_W'(SPARE_STEP + STAT_BYTES);

  logic              eng_en, start_req, start_rd, busy, accept, adv;
  logic [ADDR_W-1:0] main_base, spare_base, main_addr, spare_addr;
  logic [CNT_W-1:0]  count;

  assign accept = start_req && eng_en && !busy;

  chunk_dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .accept_i    (accept),
    .rdata_o     (reg_rdata_o),
    .eng_en_o    (eng_en),
    .incr_o      (burst_incr_o),
    .ilv_o       (interleave_o),
    .start_req_o (start_req),
    .start_rd_o  (start_rd),
    .dir_rd_o    (req_rd_o),
    .main_base_o (main_base),
    .spare_base_o(spare_base),
    .count_o     (count)
  );

  chunk_dma_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .count_i(count),
    .ack_i  (req_ack_i),
    .valid_o(req_valid_o),
    .spare_o(req_spare_o),
    .busy_o (busy),
    .done_o (done_o),
    .adv_o  (adv)
  );

  chunk_dma_seq_addr #(
    .ADDR_W(ADDR_W), .DATA_STEP(DATA_STEP),
    .SPARE_STEP(SPARE_STEP), .STAT_BYTES(STAT_BYTES)
  ) addr_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .adv_i       (adv),
    .main_base_i (main_base),
    .spare_base_i(spare_base),
    .main_addr_o (main_addr),
    .spare_addr_o(spare_addr)
  );

  assign req_addr_o = req_spare_o ? spare_addr : main_addr;
  assign req_len_o  = req_spare_o ? SPARE_LEN : MAIN_LEN;
endmodule

// File: rtl/chunk_dma_seq_chk.sv
module chunk_dma_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_spare_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_rd_o,
  input logic              req_ack_i,
  input logic              done_o,
  input logic              busy
);
  // R5
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_spare_o)));

  // R5
  spare_after_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_spare_o && req_ack_i) |=> (req_valid_o && req_spare_o));

  // R5
  main_after_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_spare_o && req_ack_i) |=> !(req_valid_o && req_spare_o));

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_valid_o);

  // R9
  dir_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(req_valid_o)) |-> $stable(req_rd_o));

  // R8
  busy_covers_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy);
endmodule

bind chunk_dma_seq chunk_dma_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_o(req_valid_o),
  .req_spare_o(req_spare_o),
  .req_addr_o (req_addr_o),
  .req_rd_o   (req_rd_o),
  .req_ack_i  (req_ack_i),
  .done_o     (done_o),
  .busy       (busy)
);

// File: tb/chunk_dma_seq_tb.sv
module chunk_dma_seq_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int DSTEP  = 1024;
  localparam int SSTEP  = 36;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              req_valid, req_spare, req_rd, req_ack = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              burst_incr, interleave, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chunk_dma_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_o(req_valid), .req_spare_o(req_spare), .req_addr_o(req_addr),
    .req_len_o(req_len), .req_rd_o(req_rd), .req_ack_i(req_ack),
    .burst_incr_o(burst_incr), .interleave_o(interleave), .done_o(done)
  );

  function automatic logic [31:0] exp_main(input logic [31:0] b, input int n);
    return b + 32'(n * DSTEP);
  endfunction
  function automatic logic [31:0] exp_spare(input logic [31:0] b, input int n);
    return b + 32'(n * SSTEP);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 40 && !req_valid; i++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [31:0] mb, input logic [31:0] sb, input int cnt,
                          input logic dir, input bit poke_busy, input int max_lat);
    logic [31:0] d;
    wr(3'd3, mb);
    wr(3'd4, sb);
    wr(3'd5, 32'(cnt));
    wr(3'd2, 32'h8000_0000 | (32'(dir) << 1));
    if (cnt == 0) begin
      check("R7 done after zero-count start", {31'b0, done}, 1);
      check("R7 no request", {31'b0, req_valid}, 0);
      @(negedge clk);
      check("R7 done single cycle", {31'b0, done}, 0);
      return;
    end
    for (int n = 0; n < cnt; n++) begin
      for (int s = 0; s < 2; s++) begin
        wait_valid();
        check("R5 request present", {31'b0, req_valid}, 1);
        check("R5 area order", {31'b0, req_spare}, 32'(s));
        if (s == 0) begin
          check("R3 main address", req_addr, exp_main(mb, n));
          check("R3 main length", 32'(req_len), DSTEP);
        end else begin
          check("R4 spare address", req_addr, exp_spare(sb, n));
          check("R4 spare length", 32'(req_len), SSTEP);
        end
        check("R9 direction", {31'b0, req_rd}, {31'b0, dir});
        if (poke_busy && n == 0 && s == 0) begin
          rd(3'd2, d);
          check("R8 busy readback", {31'b0, d[31]}, 1);
          wr(3'd5, 32'd1);
          wr(3'd3, 32'hDEAD_0000);
          wr(3'd2, 32'h8000_0000 | (32'(~dir) << 1));
          check("R8 request unchanged", req_addr, exp_main(mb, 0));
          check("R8 direction unchanged", {31'b0, req_rd}, {31'b0, dir});
        end
        for (int l = $urandom_range(max_lat, 0); l > 0; l--) @(negedge clk);
        check("R5 held until ack", {31'b0, req_valid}, 1);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        if (n == cnt - 1 && s == 1) begin
          check("R6 done after final ack", {31'b0, done}, 1);
          check("R6 no request after last", {31'b0, req_valid}, 0);
        end else begin
          check("R6 no early done", {31'b0, done}, 0);
          if (s == 0) check("R5 spare follows main ack", {31'b0, req_valid & req_spare}, 1);
        end
      end
    end
    @(negedge clk);
    check("R6 done one cycle", {31'b0, done}, 0);
    check("R6 idle after", {31'b0, req_valid}, 0);
    rd(3'd2, d);
    check("R8 busy clear", {31'b0, d[31]}, 0);
    check("R9 direction readback", {31'b0, d[1]}, {31'b0, dir});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 valid after reset", {31'b0, req_valid}, 0);
    check("R1 done after reset", {31'b0, done}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 register zero", d, 0);
    end

    // R10
    wr(3'd1, 32'h0000_0005);
    check("R10 burst incr", {31'b0, burst_incr}, 1);
    check("R10 interleave", {31'b0, interleave}, 1);
    wr(3'd1, 32'hFFFF_FFFA);
    rd(3'd1, d);
    check("R10 readback masked", d, 0);
    check("R10 packed", {31'b0, interleave}, 0);
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, d);
    check("R10 readback", d, 1);

    // R2: engine off
    wr(3'd3, 32'h1000_0000);
    wr(3'd5, 32'd2);
    wr(3'd2, 32'h8000_0002);
    check("R2 no request with engine off", {31'b0, req_valid}, 0);
    repeat (3) @(negedge clk);
    check("R2 still no request", {31'b0, req_valid | done}, 0);
    rd(3'd2, d);
    check("R2 busy stays clear", {31'b0, d[31]}, 0);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'h0000_0002);
    check("R2 no start without bit 31", {31'b0, req_valid | done}, 0);
    rd(3'd2, d);
    check("R2 dir not latched", {31'b0, d[1]}, 0);

    // directed corners
    run_xfer(32'h0000_0000, 32'h0001_0000, 0, 1'b0, 1'b0, 0);
    run_xfer(32'h2000_0000, 32'h3000_0040, 1, 1'b1, 1'b0, 0);
    run_xfer(32'h4000_0000, 32'h5000_0000, 3, 1'b1, 1'b1, 2);
    run_xfer(32'h0800_0000, 32'h0900_0000, 8, 1'b0, 1'b0, 1);
    run_xfer(32'hFFFF_F000, 32'hFFFF_FF80, 4, 1'b0, 1'b0, 0);

    for (int t = 0; t < 10; t++)
      run_xfer($urandom & 32'hFFFF_FC00, $urandom & 32'hFFFF_FFF0,
               $urandom_range(6, 1), 1'($urandom), 1'($urandom_range(3, 0) == 0), 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule